// File: doc/BRIEF.md
# SHA3-256 Padded Rate-Block Builder

This block turns a message held in a byte-wide memory into a series of 136-byte SHA3-256 rate blocks. For every block it walks all 136 byte positions. It reads the bytes that fall inside the message from the memory, and it fills the remaining positions with the SHA3 padding value that belongs at each one. The finished 1088-bit block is offered to a sponge core over a valid/ready handshake, and the last block carries a flag.

The memory has a registered read port. The block therefore issues each address one cycle before it needs the data. A one-entry writeback stage carries the byte in flight, and one extra flush cycle per block stores the final byte. A run begins with a start pulse that captures the message length and the block count. After the sponge accepts the final block, the block raises a single-cycle done pulse.

Top module: `sha3_rate_packer`

## Requirements
- R1: After a synchronous active-low reset, `blk_valid_o`, `blk_last_o` and `done_o` are low.
- R2: Byte b of block n (bits 8b+7..8b of `blk_o`) holds the memory byte at address g = n*136 + b whenever g < message length. The memory returns data one cycle after the address is presented.
- R3: The byte at g equal to the message length is 0x06.
- R4: The byte at g = blocks*136 - 1 is 0x80. When that byte is also at g equal to the message length, it is 0x86.
- R5: Every other byte position beyond the message is 0x00.
- R6: While `blk_valid_o` is high and `blk_ready_i` is low, `blk_valid_o` stays high and `blk_o` stays unchanged.
- R7: `blk_last_o` is high together with `blk_valid_o` for block index blocks-1 only, and it is never high without `blk_valid_o`.
- R8: Exactly the captured number of blocks is delivered. The next block is built only after the current one is accepted, so `blk_valid_o` is low in the cycle after acceptance.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last block is accepted.
- R10: Message length and block count are captured when start is sampled while idle. Changes on those inputs and further start pulses during a run have no effect.
- R11: `blk_valid_o` rises 137 clock edges after the edge that samples start, and 137 edges after each accepting edge of a non-final block. This covers 136 byte cycles plus one flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a run (sampled while idle) |
| msg_len_i | input | LEN_W | Message length in bytes |
| blk_cnt_i | input | BLK_W | Number of rate blocks to produce |
| mem_addr_o | output | ADDR_W | Message memory read address |
| mem_data_i | input | 8 | Memory read data, one cycle after the address |
| blk_o | output | RATE_BYTES*8 | Assembled rate block, byte 0 in the low bits |
| blk_valid_o | output | 1 | Block offered to the sponge core |
| blk_last_o | output | 1 | Offered block is the final one |
| blk_ready_i | input | 1 | Sponge core accepts the block |
| done_o | output | 1 | One-cycle pulse after the final acceptance |

## Verification
The embedded checks assume that the block count is at least one and that the message length is below the block count times 136. Under that assumption the 0x06 marker always lands inside the padded span, and in-message bytes never need a pad constant. The memory model in the stimulus returns data with exactly one cycle of latency. Every run uses a length and count pair that meets the assumption, and these pairs include the boundaries where the marker falls on the first or last byte of a block. A consumer model holds ready low for varying stretches to exercise the handshake.

// File: rtl/sha3_rate_packer.sv
module sha3_rate_packer #(
  parameter int RATE_BYTES = 136,
  parameter int LEN_W      = 12,
  parameter int ADDR_W     = 11,
  parameter int BLK_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        msg_len_i,
  input  logic [BLK_W-1:0]        blk_cnt_i,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic [7:0]              mem_data_i,
  output logic [RATE_BYTES*8-1:0] blk_o,
  output logic                    blk_valid_o,
  output logic                    blk_last_o,
  input  logic                    blk_ready_i,
  output logic                    done_o
);
  localparam int BYTE_W = $clog2(RATE_BYTES + 1);
  localparam logic [BYTE_W-1:0] FLUSH = BYTE_W'(RATE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_ASM, S_FEED} st_t;
  st_t st;

  logic [LEN_W-1:0]  len_q;
  logic [BLK_W-1:0]  cnt_q;
  logic [BLK_W-1:0]  blk_q;
  logic [BYTE_W-1:0] byte_q;

  logic              wb_vld;
  logic [BYTE_W-1:0] wb_idx;
  logic [LEN_W-1:0]  wb_g;
  logic              wb_inmsg;
  logic [7:0]        wb_pad;

  logic [LEN_W-1:0]  g_now;
  logic [LEN_W-1:0]  pad_end;
  logic              hit_len, hit_end;
  logic [7:0]        pad_now;

  assign g_now      = LEN_W'(blk_q) * LEN_W'(RATE_BYTES) + LEN_W'(byte_q);
  assign pad_end    = LEN_W'(cnt_q) * LEN_W'(RATE_BYTES) - LEN_W'(1);
  assign hit_len    = (g_now == len_q);
  assign hit_end    = (g_now == pad_end);
  assign pad_now    = {hit_end, 4'b0000, hit_len, hit_len, 1'b0};
  assign mem_addr_o = g_now[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      len_q       <= '0;
      cnt_q       <= '0;
      blk_q       <= '0;
      byte_q      <= '0;
      wb_vld      <= 1'b0;
      wb_idx      <= '0;
      wb_g        <= '0;
      wb_inmsg    <= 1'b0;
      wb_pad      <= '0;
      blk_o       <= '0;
      blk_valid_o <= 1'b0;
      blk_last_o  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            len_q  <= msg_len_i;
            cnt_q  <= blk_cnt_i;
            blk_q  <= '0;
            byte_q <= '0;
            wb_vld <= 1'b0;
            st     <= S_ASM;
          end
        end
        S_ASM: begin
          if (wb_vld)
            blk_o[int'(wb_idx)*8 +: 8] <= wb_inmsg ? mem_data_i : wb_pad;
          if (byte_q != FLUSH) begin
            wb_vld   <= 1'b1;
            wb_idx   <= byte_q;
            wb_g     <= g_now;
            wb_inmsg <= (g_now < len_q);
            wb_pad   <= pad_now;
            byte_q   <= byte_q + BYTE_W'(1);
          end else begin
            wb_vld      <= 1'b0;
            byte_q      <= '0;
            blk_valid_o <= 1'b1;
            blk_last_o  <= (blk_q == cnt_q - BLK_W'(1));
            st          <= S_FEED;
          end
        end
        S_FEED: begin
          if (blk_ready_i) begin
            blk_valid_o <= 1'b0;
            blk_last_o  <= 1'b0;
            if (blk_last_o) begin
              done_o <= 1'b1;
              st     <= S_IDLE;
            end else begin
              blk_q <= blk_q + BLK_W'(1);
              st    <= S_ASM;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid_o && !blk_ready_i) |=> (blk_valid_o && $stable(blk_o)));

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last_o |-> blk_valid_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  no_build_while_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid_o |-> !wb_vld);

  // R2
  inmsg_byte_nopad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && wb_inmsg) |-> (wb_pad == 8'h00 && wb_g < len_q));

  // R10
  capture_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(len_q) && $stable(cnt_q)));
endmodule

// File: tb/sha3_rate_packer_tb_top.sv
module sha3_rate_packer_tb_top;
  localparam int RB = 136;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [11:0] msg_len_i = '0;
  logic [3:0] blk_cnt_i = '0;
  logic [10:0] mem_addr_o;
  logic [7:0] mem_data_i;
  logic [RB*8-1:0] blk_o;
  logic blk_valid_o, blk_last_o, done_o;
  logic blk_ready_i = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] mem [0:2047];

  always #2 clk = ~clk;

  always_ff @(posedge clk) mem_data_i <= mem[mem_addr_o];

  sha3_rate_packer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .msg_len_i(msg_len_i),
    .blk_cnt_i(blk_cnt_i), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .blk_o(blk_o), .blk_valid_o(blk_valid_o), .blk_last_o(blk_last_o),
    .blk_ready_i(blk_ready_i), .done_o(done_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_sim();
    end
  end

  // wait for valid, counting edges; returns count
  task automatic wait_valid(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!blk_valid_o && n < 1000);
  endtask

  task automatic check_block(input int n, input int len, input int cnt);
    for (int b = 0; b < RB; b++) begin
      int g = n * RB + b;
      logic [7:0] e = 8'h00;
      string tag = "R5";
      if (g < len) begin e = mem[g]; tag = "R2"; end
      else begin
        if (g == len) begin e = e | 8'h06; tag = "R3"; end
        if (g == cnt * RB - 1) begin e = e | 8'h80; tag = "R4"; end
      end
      chk(blk_o[b*8 +: 8] == e, tag, blk_o[b*8 +: 8], e);
    end
  endtask

  task automatic run_msg(input int len, input int cnt, input int hold, input bit disturb);
    int n;
    @(negedge clk);
    msg_len_i = 12'(len); blk_cnt_i = 4'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      // R10: new length, count and start during the run must be ignored
      msg_len_i = 12'd5; blk_cnt_i = 4'd1; start_i = 1'b1;
      @(negedge clk); @(negedge clk);
      start_i = 1'b0;
    end
    for (int k = 0; k < cnt; k++) begin
      wait_valid(n);
      if (disturb && k == 0) n = n + 2;
      chk(n == 137, "R11", n, 137);
      chk(blk_last_o == (k == cnt - 1), "R7", blk_last_o, (k == cnt - 1));
      check_block(k, len, cnt);
      for (int h = 0; h < hold + k % 3; h++) begin
        logic [RB*8-1:0] snap = blk_o;
        @(negedge clk);
        chk(blk_valid_o && blk_o == snap, "R6", blk_valid_o, 1);
      end
      blk_ready_i = 1'b1;
      @(negedge clk);
      blk_ready_i = 1'b0;
      chk(!blk_valid_o, "R8", blk_valid_o, 0);
      chk(done_o == (k == cnt - 1), "R9", done_o, (k == cnt - 1));
    end
    @(negedge clk);
    chk(!done_o, "R9", done_o, 0);
    chk(!blk_valid_o, "R8", blk_valid_o, 0);
  endtask

  task automatic check_reset();
    chk(!blk_valid_o, "R1", blk_valid_o, 0);
    chk(!blk_last_o, "R1", blk_last_o, 0);
    chk(!done_o, "R1", done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'(i * 37 + 11) ^ 8'(i >> 8);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    run_msg(800, 6, 2, 1'b0);
    run_msg(135, 1, 0, 1'b0);
    run_msg(136, 2, 1, 1'b0);
    run_msg(0, 1, 3, 1'b0);
    run_msg(1184, 9, 1, 1'b1);
    run_msg(271, 2, 0, 1'b0);
    finish_sim();
  end
endmodule